// File: doc/BRIEF.md
# Dual-Rail Reset Supervisor Controller

This block is the digital sequencing core of a supervisor that watches two power rails. Analog comparators outside the block report whether each rail is above its threshold. A supply power-on-good flag and a manual reset input also come in. All four inputs are asynchronous. The block drives one registered output, `pull_o`. When `pull_o` is high, an open-drain pad outside the block pulls the active-low system reset line down.

Each rail flag is synchronized and then filtered, so that a short excursion in either direction is ignored. Reset is requested at once when power-on drops or the manual reset input is high. It is requested after the filter window when a rail goes bad. Reset is released only after every condition has been good for an uninterrupted recovery period. Both time spans are parameters counted in clock cycles: the defaults are 20 µs and 300 ms at 125 MHz.

Top module: `dual_rail_supervisor`

## Requirements
- R1: `pull_o` = 1 means reset is requested (pin pulled low). `pull_o` is 0 only if, one edge earlier, power-on was good, both filtered rail flags were good and the synchronized manual reset was low.
- R2: Each rail flag passes a two-flop synchronizer. The filtered flag takes the new level only after the synchronized sample has differed from it on `DEGLITCH_CYCLES` consecutive edges. A pulse that is sampled on fewer edges, bad or good, leaves `pull_o` unchanged.
- R3: A rail drop that lasts at least `DEGLITCH_CYCLES` edges raises `pull_o` on edge `DEGLITCH_CYCLES`+3, counting the first edge that samples the drop as edge 1. `pull_o` stays high for as long as the drop lasts.
- R4: Manual reset high raises `pull_o` on edge 3, counting the first edge that samples it as edge 1, whatever the rail state.
- R5: Power-on low raises `pull_o` on edge 3 and clears both filters and the release timer. When power-on returns with both rails good, `pull_o` falls on edge `DEGLITCH_CYCLES`+`RELEASE_CYCLES`+3, counting the first edge that samples power-on good as edge 1.
- R6: When a rail becomes good last, `pull_o` falls on edge `DEGLITCH_CYCLES`+`RELEASE_CYCLES`+3, counting the first edge that samples the good level as edge 1.
- R7: If any condition drops while the release count runs, the count restarts from zero.
- R8: Synchronous reset `rst` sets `pull_o` to 1, clears the filters and presets the manual reset synchronizer to the asserted level. This models an input that is pulled up. After `rst` falls with all inputs good, `pull_o` falls on edge `DEGLITCH_CYCLES`+`RELEASE_CYCLES`+3.
- R9: When manual reset falls while the rails are good, the full delay runs again. `pull_o` falls on edge `RELEASE_CYCLES`+3, counting the first edge that samples it low as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok_i | input | 1 | Supply power-on-good flag, asynchronous |
| rail_a_ok_i | input | 1 | First rail above threshold, asynchronous |
| rail_b_ok_i | input | 1 | Second rail above threshold, asynchronous |
| man_rst_i | input | 1 | Manual reset request, active high, asynchronous |
| pull_o | output | 1 | 1 = drive the active-low reset pin low |

## Verification
The hardest state to reach from the ports is a restart of the release count partway through. Every drop of a condition also forces `pull_o` high, so a restart cannot be seen directly at the output. The only evidence is the time at which `pull_o` finally falls. The stimulus lets the count run to about half its length, then pulses manual reset for a single edge. It then measures that the fall comes a full `RELEASE_CYCLES`+3 edges after the pulse. Sub-window pulses in both directions get the same treatment: the bench checks that `pull_o` keeps its level through and well past each pulse.

// File: rtl/dual_rail_pkg.sv
package dual_rail_pkg;
  localparam int NUM_RAILS = 2;
  localparam int SYNC_W    = NUM_RAILS + 2;
  // synchronizer lane order
  localparam int LANE_POR  = NUM_RAILS + 1;
  localparam int LANE_MR   = NUM_RAILS;

  function automatic int cnt_width(input int cycles);
    return $clog2(cycles + 1);
  endfunction
endpackage

// File: rtl/dr_sync2.sv
module dr_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dr_glitch_filt.sv
module dr_glitch_filt
  import dual_rail_pkg::*;
#(
  parameter int CYCLES = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic smp,
  output logic q
);
  localparam int CW = cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q     <= 1'b0;
      run_q <= '0;
    end else if (smp != q) begin
      if (run_q == LAST) begin
        q     <= smp;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/dr_release_timer.sv
module dr_release_timer
  import dual_rail_pkg::*;
#(
  parameter int CYCLES = 37_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic good,
  output logic done
);
  localparam int CW = cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !good) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      if (cnt_q == LAST) done  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dual_rail_supervisor.sv
module dual_rail_supervisor
  import dual_rail_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 2500,
  parameter int RELEASE_CYCLES  = 37_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic por_ok_i,
  input  logic rail_a_ok_i,
  input  logic rail_b_ok_i,
  input  logic man_rst_i,
  output logic pull_o
);
  // manual reset lane presets high: an open input reads as asserted
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << LANE_MR;

  logic [SYNC_W-1:0]    sync_q;
  logic [NUM_RAILS-1:0] rail_s;
  logic [NUM_RAILS-1:0] rail_ok_f;
  logic                 por_s;
  logic                 mr_s;
  logic                 all_good;
  logic                 rel_done;

  dr_sync2 #(.W(SYNC_W), .RST_VAL(SYNC_RST)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({por_ok_i, man_rst_i, rail_b_ok_i, rail_a_ok_i}),
    .q   (sync_q)
  );

  assign rail_s = sync_q[NUM_RAILS-1:0];
  assign mr_s   = sync_q[LANE_MR];
  assign por_s  = sync_q[LANE_POR];

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_filt
    dr_glitch_filt #(.CYCLES(DEGLITCH_CYCLES)) filt_i (
      .clk (clk),
      .rst (rst),
      .clr (!por_s),
      .smp (rail_s[i]),
      .q   (rail_ok_f[i])
    );
  end

  assign all_good = por_s && (&rail_ok_f) && !mr_s;

  dr_release_timer #(.CYCLES(RELEASE_CYCLES)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .good (all_good),
    .done (rel_done)
  );

  always_ff @(posedge clk) begin
    if (rst) pull_o <= 1'b1;
    else     pull_o <= !(all_good && rel_done);
  end
endmodule

// File: rtl/dual_rail_checker.sv
module dual_rail_checker #(
  parameter int RELEASE_CYCLES = 37_500_000
) (
  input logic       clk,
  input logic       rst,
  input logic       pull_o,
  input logic       por_s,
  input logic       mr_s,
  input logic [1:0] rail_s,
  input logic [1:0] rail_ok_f
);
  int unsigned good_run;
  logic        cond_ok;

  assign cond_ok = por_s && (rail_ok_f == 2'b11) && !mr_s;

  always_ff @(posedge clk) begin
    if (rst || !cond_ok)             good_run <= 0;
    else if (good_run != 32'hFFFF_FFFF) good_run <= good_run + 1;
  end

  assert_release_needs_all_good_R1: assert property (@(posedge clk) disable iff (rst)
    !pull_o |-> $past(por_s && (rail_ok_f == 2'b11) && !mr_s));

  assert_filter_follows_sample_a_R2: assert property (@(posedge clk) disable iff (rst)
    ((rail_ok_f[0] != $past(rail_ok_f[0])) && $past(por_s)) |-> (rail_ok_f[0] == $past(rail_s[0])));

  assert_filter_follows_sample_b_R2: assert property (@(posedge clk) disable iff (rst)
    ((rail_ok_f[1] != $past(rail_ok_f[1])) && $past(por_s)) |-> (rail_ok_f[1] == $past(rail_s[1])));

  assert_rail_bad_holds_reset_R3: assert property (@(posedge clk) disable iff (rst)
    (rail_ok_f != 2'b11) |=> pull_o);

  assert_manual_forces_reset_R4: assert property (@(posedge clk) disable iff (rst)
    mr_s |=> pull_o);

  assert_por_low_forces_reset_R5: assert property (@(posedge clk) disable iff (rst)
    !por_s |=> pull_o);

  assert_release_after_full_delay_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_o) |-> (good_run >= RELEASE_CYCLES));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> pull_o);
endmodule

bind dual_rail_supervisor dual_rail_checker #(.RELEASE_CYCLES(RELEASE_CYCLES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .pull_o    (pull_o),
  .por_s     (por_s),
  .mr_s      (mr_s),
  .rail_s    (rail_s),
  .rail_ok_f (rail_ok_f)
);

// File: tb/dual_rail_supervisor_tb_top.sv
module dual_rail_supervisor_tb_top;
  localparam int D = 4;
  localparam int R = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_ok_i = 1'b1;
  logic rail_a_ok_i = 1'b1;
  logic rail_b_ok_i = 1'b1;
  logic man_rst_i = 1'b0;
  logic pull_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;
  string cur_req = "R8";

  always #4 clk = ~clk;   // 125 MHz

  dual_rail_supervisor #(.DEGLITCH_CYCLES(D), .RELEASE_CYCLES(R)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .por_ok_i    (por_ok_i),
    .rail_a_ok_i (rail_a_ok_i),
    .rail_b_ok_i (rail_b_ok_i),
    .man_rst_i   (man_rst_i),
    .pull_o      (pull_o)
  );

  // behavioural reference: delayed samples, run lengths, good-time counter
  logic [3:0] m_hist [2];   // {por, mr, b, a}, two edges of delay
  bit m_fa, m_fb, m_done, m_pull;
  int m_ra, m_rb, m_good;

  always @(posedge clk) begin
    if (rst) begin
      m_hist[0] = 4'b0100; m_hist[1] = 4'b0100;
      m_fa = 0; m_fb = 0; m_ra = 0; m_rb = 0;
      m_good = 0; m_done = 0; m_pull = 1;
    end else begin
      bit ok;
      bit por_d;
      ok = m_hist[1][3] && !m_hist[1][2] && m_fa && m_fb;
      m_pull = !(ok && m_done);
      if (!ok) begin
        m_good = 0; m_done = 0;
      end else if (!m_done) begin
        m_good++;
        if (m_good == R) m_done = 1;
      end
      por_d = m_hist[1][3];
      if (!por_d) begin
        m_fa = 0; m_ra = 0; m_fb = 0; m_rb = 0;
      end else begin
        if (m_hist[1][0] != m_fa) begin
          m_ra++;
          if (m_ra == D) begin m_fa = m_hist[1][0]; m_ra = 0; end
        end else m_ra = 0;
        if (m_hist[1][1] != m_fb) begin
          m_rb++;
          if (m_rb == D) begin m_fb = m_hist[1][1]; m_rb = 0; end
        end else m_rb = 0;
      end
      m_hist[1] = m_hist[0];
      m_hist[0] = {por_ok_i, man_rst_i, rail_b_ok_i, rail_a_ok_i};
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!finished) begin
      n_checks++;
      if (pull_o !== m_pull) begin
        n_fail++;
        $display("FAIL %s: per-cycle pull_o actual %0b expected %0b at %0t", cur_req, pull_o, m_pull, $time);
      end
    end
  end

  task automatic check_val(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // count edges until pull_o reaches the wanted level (first edge is 1)
  task automatic count_until(input logic want, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (pull_o !== want && n < 1000);
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    int n;
    wait_cyc(5);
    cur_req = "R8";
    check_val("R8 reset state", pull_o, 1);
    rst = 1'b0;
    count_until(1'b0, n);
    check_val("R8 release after reset", n, D + R + 3);

    // short bad pulse on rail a
    cur_req = "R2";
    rail_a_ok_i = 1'b0; wait_cyc(D - 1); rail_a_ok_i = 1'b1;
    wait_cyc(2 * D + 6);
    check_val("R2 short bad pulse ignored", pull_o, 0);

    // real rail drop and recovery
    cur_req = "R3";
    rail_a_ok_i = 1'b0;
    count_until(1'b1, n);
    check_val("R3 drop latency", n, D + 3);
    wait_cyc(30);
    check_val("R3 held while bad", pull_o, 1);
    cur_req = "R6";
    rail_a_ok_i = 1'b1;
    count_until(1'b0, n);
    check_val("R6 release after rail good", n, D + R + 3);

    // short good pulse on a bad rail
    cur_req = "R2";
    rail_b_ok_i = 1'b0;
    count_until(1'b1, n);
    check_val("R3 rail b drop latency", n, D + 3);
    rail_b_ok_i = 1'b1; wait_cyc(D - 1); rail_b_ok_i = 1'b0;
    wait_cyc(2 * D + R + 10);
    check_val("R2 short good pulse ignored", pull_o, 1);
    cur_req = "R6";
    rail_b_ok_i = 1'b1;
    count_until(1'b0, n);
    check_val("R6 release after rail b good", n, D + R + 3);

    // manual reset with rail a also bad, then with rails good
    cur_req = "R4";
    man_rst_i = 1'b1;
    count_until(1'b1, n);
    check_val("R4 manual assert latency", n, 3);
    rail_a_ok_i = 1'b0; wait_cyc(D + 5); rail_a_ok_i = 1'b1;
    wait_cyc(D + R + 10);
    check_val("R4 manual overrides good rails", pull_o, 1);
    cur_req = "R9";
    man_rst_i = 1'b0;
    count_until(1'b0, n);
    check_val("R9 full delay after manual release", n, R + 3);

    // restart of the release count by a one-edge manual pulse
    cur_req = "R7";
    man_rst_i = 1'b1; wait_cyc(10);
    man_rst_i = 1'b0; wait_cyc(R / 2);
    man_rst_i = 1'b1; wait_cyc(1);
    man_rst_i = 1'b0;
    count_until(1'b0, n);
    check_val("R7 count restarted", n, R + 3);

    // power-on drop clears everything
    cur_req = "R5";
    por_ok_i = 1'b0;
    count_until(1'b1, n);
    check_val("R5 power-on drop latency", n, 3);
    por_ok_i = 1'b1;
    count_until(1'b0, n);
    check_val("R5 requalify after power-on", n, D + R + 3);

    cur_req = "R1";
    wait_cyc(20);
    check_val("R1 steady released", pull_o, 0);
    summary();
  end
endmodule